// File: doc/BRIEF.md
# Real-Time Clock Alarm Match and Repeat Controller

This block sits next to a real-time clock counter and decides when an alarm goes off. On every time-base tick it compares the current calendar time with a stored alarm time. The time arrives as a half-second phase flag plus BCD seconds, minutes, hours, weekday, day and month. A period code selects which of those fields must agree. The period can be anything from every half second to once a year. When the compare succeeds while the alarm is armed, the block emits a one-cycle event pulse.

A repeat count limits how many events occur. It counts down on each event. In one-shot mode the count sticks at zero, and the last event disarms the alarm. In continuous (chime) mode the count wraps from zero to its maximum and the alarm stays armed.

Software reaches the block through a small register port. Select 0 is a 16-bit control word. Select 1 is a 16-bit window onto the six alarm time bytes. A 2-bit slot pointer held in the control word picks which pair of bytes is visible in the window. Every access to the window's upper byte steps the pointer down by one, so a burst of accesses walks the alarm fields without rewriting the control word.

Top module: `rtc_alarm_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000, every alarm byte reads 0x00 and `alarm_evt` is low.
- R2: The period code is in control bits 13:10. With code 0 every tick fires. For codes 1 to 9 the tick must also have `now_half`=0, and these fields must also agree:
  - code 1: nothing more.
  - code 2: the seconds low digit.
  - code 3: seconds.
  - code 4: the minutes low digit plus seconds.
  - code 5: minutes and seconds.
  - code 6: hours, minutes and seconds.
  - code 7: weekday, hours, minutes and seconds.
  - code 8: day, hours, minutes and seconds.
  - code 9: month, day, hours, minutes and seconds.
- R3: In code 9, an alarm set to month 0x02, day 0x29 fires only on a tick whose date is month 0x02, day 0x29. Neighbouring dates do not fire, so the event occurs once per leap cycle.
- R4: Codes 10 to 15 never produce an event.
- R5: `alarm_evt` is high for exactly the one cycle after a tick cycle on which the armed bit (control bit 15) is set and the compare succeeds, and low otherwise.
- R6: An event with a nonzero repeat count (control bits 7:0) lowers the count by one and leaves the alarm armed.
- R7: With chime (control bit 14) clear, an event at count 0x00 leaves the count at 0x00 and clears the armed bit.
- R8: With chime set, an event at count 0x00 loads 0xFF and keeps the armed bit set.
- R9: A control write loads all 16 bits in one step: armed at 15, chime at 14, period code at 13:10, slot pointer at 9:8, repeat count at 7:0. Reads return the same layout.
- R10: The window maps the slot pointer to fields as follows. Upper byte (bits 15:8): 0 = minutes, 1 = weekday, 2 = month. Lower byte (bits 7:0): 0 = seconds, 1 = hours, 2 = day. Byte enable bit 1 selects the upper byte and bit 0 selects the lower byte.
- R11: A window read or write with byte enable bit 1 set lowers a nonzero slot pointer by one and leaves a zero pointer at zero. A lower-byte-only access leaves the pointer unchanged.
- R12: Slot 3 reads as 0x0000, and writes to slot 3 change no alarm byte.
- R13: A control write in the same cycle as an event takes priority. The written value replaces the automatic count step and the automatic disarm, while the event pulse is still produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the alarm window |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (has side effects on the window) |
| reg_be | input | 2 | Window byte enables: bit 1 upper, bit 0 lower |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| tick | input | 1 | Time-base strobe, one cycle per half second |
| now_half | input | 1 | Current half-second phase (1 = second half) |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_wday | input | 8 | Current weekday |
| now_day | input | 8 | Current day of month, BCD |
| now_month | input | 8 | Current month, BCD |
| alarm_evt | output | 1 | One-cycle alarm event pulse |

## Verification
Software can rewrite the control word in the very cycle on which a tick produces an event. In that cycle the automatic count step and disarm collide with the software load. The bench provokes this by raising `tick` and a control write in the same clock cycle while the alarm is in one-shot mode at count zero. It then judges three things: the event pulse still appears, and the control word read back afterwards holds exactly the written armed bit and count rather than a disarmed, held zero.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int FIELD_W = 8;
  localparam int CODE_W  = 4;
  localparam int PTR_W   = 2;
  localparam int CNT_W   = 8;
  localparam int WORD_W  = 2 * FIELD_W;
  localparam int SLOTS   = 3;

  typedef enum logic [CODE_W-1:0] {
    PER_HALF  = 4'd0, PER_SEC   = 4'd1, PER_10SEC = 4'd2, PER_MIN  = 4'd3,
    PER_10MIN = 4'd4, PER_HOUR  = 4'd5, PER_DAY   = 4'd6, PER_WEEK = 4'd7,
    PER_MONTH = 4'd8, PER_YEAR  = 4'd9
  } period_e;

  typedef struct packed {
    logic [FIELD_W-1:0] month;
    logic [FIELD_W-1:0] day;
    logic [FIELD_W-1:0] wday;
    logic [FIELD_W-1:0] hour;
    logic [FIELD_W-1:0] min;
    logic [FIELD_W-1:0] sec;
  } tod_t;

  // Masked compare of current time against alarm time for a period code.
  function automatic logic period_hit(logic [CODE_W-1:0] code, logic half,
                                      tod_t now, tod_t alm);
    logic s1, s2, m1, m2, h, w, d, mo;
    s1 = (now.sec[3:0] == alm.sec[3:0]);
    s2 = (now.sec == alm.sec);
    m1 = (now.min[3:0] == alm.min[3:0]);
    m2 = (now.min == alm.min);
    h  = (now.hour == alm.hour);
    w  = (now.wday == alm.wday);
    d  = (now.day == alm.day);
    mo = (now.month == alm.month);
    case (code)
      PER_HALF:  period_hit = 1'b1;
      PER_SEC:   period_hit = !half;
      PER_10SEC: period_hit = !half && s1;
      PER_MIN:   period_hit = !half && s2;
      PER_10MIN: period_hit = !half && s2 && m1;
      PER_HOUR:  period_hit = !half && s2 && m2;
      PER_DAY:   period_hit = !half && s2 && m2 && h;
      PER_WEEK:  period_hit = !half && s2 && m2 && h && w;
      PER_MONTH: period_hit = !half && s2 && m2 && h && d;
      PER_YEAR:  period_hit = !half && s2 && m2 && h && d && mo;
      default:   period_hit = 1'b0;
    endcase
  endfunction

  // Repeat count after one event: down by one, wrap only in chime mode.
  function automatic logic [CNT_W-1:0] count_step(logic [CNT_W-1:0] cnt, logic chime);
    if (cnt != '0)  count_step = cnt - 1'b1;
    else if (chime) count_step = '1;
    else            count_step = '0;
  endfunction
endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              armed,
  input  logic [CODE_W-1:0] code,
  input  logic              half,
  input  tod_t              now,
  input  tod_t              alm,
  output logic              fire,
  output logic              evt_q
);
  logic hit;
  assign hit  = period_hit(code, half, now, alm);
  assign fire = tick && armed && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= fire;
  end
endmodule

// File: rtl/rtc_alarm_cfg.sv
module rtc_alarm_cfg
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              fire,
  input  logic              hi_acc,
  output logic              armed,
  output logic              chime,
  output logic [CODE_W-1:0] code,
  output logic [PTR_W-1:0]  ptr,
  output logic [CNT_W-1:0]  cnt,
  output logic [WORD_W-1:0] word
);
  assign word = {armed, chime, code, ptr, cnt};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      chime <= 1'b0;
      code  <= '0;
      ptr   <= '0;
      cnt   <= '0;
    end else if (cfg_wr) begin
      {armed, chime, code, ptr, cnt} <= wdata;
    end else begin
      if (fire) begin
        cnt <= count_step(cnt, chime);
        if (cnt == '0 && !chime) armed <= 1'b0;
      end
      if (hi_acc && ptr != '0) ptr <= ptr - 1'b1;
    end
  end
endmodule

// File: rtl/rtc_alarm_win.sv
module rtc_alarm_win
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_wr,
  input  logic [1:0]        be,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output tod_t              alm
);
  logic [FIELD_W-1:0] lo_q [SLOTS];
  logic [FIELD_W-1:0] hi_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[g] <= '0;
        hi_q[g] <= '0;
      end else if (win_wr && ptr == PTR_W'(g)) begin
        if (be[0]) lo_q[g] <= wdata[FIELD_W-1:0];
        if (be[1]) hi_q[g] <= wdata[WORD_W-1:FIELD_W];
      end
    end
  end

  always_comb begin
    case (ptr)
      2'd0:    rdata = {hi_q[0], lo_q[0]};
      2'd1:    rdata = {hi_q[1], lo_q[1]};
      2'd2:    rdata = {hi_q[2], lo_q[2]};
      default: rdata = '0;
    endcase
  end

  assign alm.sec   = lo_q[0];
  assign alm.hour  = lo_q[1];
  assign alm.day   = lo_q[2];
  assign alm.min   = hi_q[0];
  assign alm.wday  = hi_q[1];
  assign alm.month = hi_q[2];
endmodule

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_be,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              tick,
  input  logic              now_half,
  input  logic [FIELD_W-1:0] now_sec,
  input  logic [FIELD_W-1:0] now_min,
  input  logic [FIELD_W-1:0] now_hour,
  input  logic [FIELD_W-1:0] now_wday,
  input  logic [FIELD_W-1:0] now_day,
  input  logic [FIELD_W-1:0] now_month,
  output logic              alarm_evt
);
  logic              cfg_wr, win_wr, hi_acc, fire;
  logic              armed, chime;
  logic [CODE_W-1:0] code;
  logic [PTR_W-1:0]  ptr;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] cfg_word, win_word;
  tod_t              now, alm;

  assign cfg_wr = reg_wr && !reg_sel;
  assign win_wr = reg_wr && reg_sel;
  assign hi_acc = reg_sel && (reg_wr || reg_rd) && reg_be[1];
  assign now    = '{month: now_month, day: now_day, wday: now_wday,
                    hour: now_hour, min: now_min, sec: now_sec};
  assign reg_rdata = reg_sel ? win_word : cfg_word;

  rtc_alarm_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .wdata(reg_wdata), .fire(fire),
    .hi_acc(hi_acc), .armed(armed), .chime(chime), .code(code), .ptr(ptr),
    .cnt(cnt), .word(cfg_word)
  );

  rtc_alarm_win u_win (
    .clk(clk), .rst_n(rst_n), .win_wr(win_wr), .be(reg_be), .ptr(ptr),
    .wdata(reg_wdata), .rdata(win_word), .alm(alm)
  );

  rtc_alarm_match u_match (
    .clk(clk), .rst_n(rst_n), .tick(tick), .armed(armed), .code(code),
    .half(now_half), .now(now), .alm(alm), .fire(fire), .evt_q(alarm_evt)
  );
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk
  import rtc_alarm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              fire,
  input logic              tick,
  input logic              alarm_evt,
  input logic              cfg_wr,
  input logic              hi_acc,
  input logic              armed,
  input logic              chime,
  input logic [CODE_W-1:0] code,
  input logic [PTR_W-1:0]  ptr,
  input logic [CNT_W-1:0]  cnt,
  input logic [WORD_W-1:0] cfg_word,
  input logic [WORD_W-1:0] reg_wdata
);
  assert_evt_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> alarm_evt);
  assert_evt_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !alarm_evt);
  assert_reserved_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && code > 4'd9) |-> !fire);
  assert_count_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cfg_wr && cnt != '0) |=> (cnt == $past(cnt) - 1'b1) && armed);
  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cfg_wr && cnt == '0 && !chime) |=> (cnt == '0) && !armed);
  assert_count_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cfg_wr && cnt == '0 && chime) |=> (cnt == '1) && armed);
  assert_ptr_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_acc && ptr != '0) |=> ptr == $past(ptr) - 1'b1);
  assert_ptr_floor_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_acc && ptr == '0) |=> ptr == '0);
  assert_sw_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_word == $past(reg_wdata));
endmodule

bind rtc_alarm_ctrl rtc_alarm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fire(fire), .tick(tick), .alarm_evt(alarm_evt),
  .cfg_wr(cfg_wr), .hi_acc(hi_acc), .armed(armed), .chime(chime), .code(code),
  .ptr(ptr), .cnt(cnt), .cfg_word(cfg_word), .reg_wdata(reg_wdata)
);

// File: tb/rtc_alarm_ctrl_test.sv
module rtc_alarm_ctrl_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_be = 2'b00;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        tick = 1'b0, now_half = 1'b0;
  logic [7:0]  now_sec = '0, now_min = '0, now_hour = '0, now_wday = '0,
               now_day = '0, now_month = '0;
  logic        alarm_evt;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Alarm values currently programmed, as the bench believes them to be.
  logic [7:0] a_sec, a_min, a_hour, a_wday, a_day, a_mon;

  always #10 clk = ~clk;

  rtc_alarm_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
    .now_half(now_half), .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_wday(now_wday), .now_day(now_day), .now_month(now_month),
    .alarm_evt(alarm_evt)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    reg_sel = sel; reg_be = be; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 2'b00;
  endtask

  task automatic rd(input logic sel, input logic [1:0] be, output logic [15:0] v);
    @(negedge clk);
    reg_sel = sel; reg_be = be; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; reg_be = 2'b00;
  endtask

  task automatic set_now(input bit h, input logic [7:0] mo, d, w, hr, mi, s);
    now_half = h; now_month = mo; now_day = d; now_wday = w;
    now_hour = hr; now_min = mi; now_sec = s;
  endtask

  // One tick; returns alarm_evt in the cycle after the tick and the one after that.
  task automatic pulse_tick(output logic ev, output logic ev_next);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; ev = alarm_evt;
    @(negedge clk); ev_next = alarm_evt;
  endtask

  task automatic set_alarm(input logic [7:0] mo, d, w, hr, mi, s);
    wr(1'b0, 2'b00, 16'h0200);
    wr(1'b1, 2'b11, {mo, d});
    wr(1'b1, 2'b11, {w, hr});
    wr(1'b1, 2'b11, {mi, s});
    a_mon = mo; a_day = d; a_wday = w; a_hour = hr; a_min = mi; a_sec = s;
  endtask

  function automatic bit expect_fire(int c, bit h, logic [7:0] mo, d, w, hr, mi, s);
    bit ok = 1;
    if (c > 9) return 0;
    if (c == 0) return 1;
    if (h) return 0;
    if (c >= 2 && s[3:0] != a_sec[3:0]) ok = 0;
    if (c >= 3 && s != a_sec) ok = 0;
    if (c >= 4 && mi[3:0] != a_min[3:0]) ok = 0;
    if (c >= 5 && mi != a_min) ok = 0;
    if (c >= 6 && hr != a_hour) ok = 0;
    if (c == 7 && w != a_wday) ok = 0;
    if (c >= 8 && d != a_day) ok = 0;
    if (c == 9 && mo != a_mon) ok = 0;
    return ok;
  endfunction

  task automatic t_reset();
    logic [15:0] v;
    check(alarm_evt == 1'b0, "R1 evt", {15'd0, alarm_evt}, 16'h0);
    rd(1'b0, 2'b00, v); check(v == 16'h0000, "R1 ctrl", v, 16'h0000);
    rd(1'b1, 2'b01, v); check(v == 16'h0000, "R1 window", v, 16'h0000);
  endtask

  task automatic t_window();
    logic [15:0] v;
    set_alarm(8'h12, 8'h25, 8'h03, 8'h14, 8'h30, 8'h45);
    rd(1'b0, 2'b00, v); check(v[9:8] == 2'd0, "R11 ptr floor after writes", v, 16'h0);
    wr(1'b1, 2'b11, {8'h30, 8'h45});
    rd(1'b0, 2'b00, v); check(v[9:8] == 2'd0, "R11 ptr stays 0", v, 16'h0);
    wr(1'b0, 2'b00, 16'h0200);
    rd(1'b1, 2'b11, v); check(v == 16'h1225, "R10 slot2 month/day", v, 16'h1225);
    rd(1'b1, 2'b11, v); check(v == 16'h0314, "R10 slot1 wday/hour", v, 16'h0314);
    rd(1'b1, 2'b11, v); check(v == 16'h3045, "R10 slot0 min/sec", v, 16'h3045);
    wr(1'b0, 2'b00, 16'h0200);
    rd(1'b1, 2'b01, v);
    rd(1'b0, 2'b00, v); check(v[9:8] == 2'd2, "R11 low-only keeps ptr", {14'd0, v[9:8]}, 16'd2);
    wr(1'b0, 2'b00, 16'h0300);
    rd(1'b1, 2'b01, v); check(v == 16'h0000, "R12 slot3 reads zero", v, 16'h0000);
    wr(1'b1, 2'b11, 16'hFFFF);
    rd(1'b0, 2'b00, v); check(v[9:8] == 2'd2, "R11 ptr 3->2", {14'd0, v[9:8]}, 16'd2);
    rd(1'b1, 2'b11, v); check(v == 16'h1225, "R12 slot2 untouched", v, 16'h1225);
    rd(1'b1, 2'b11, v); check(v == 16'h0314, "R12 slot1 untouched", v, 16'h0314);
    rd(1'b1, 2'b11, v); check(v == 16'h3045, "R12 slot0 untouched", v, 16'h3045);
    wr(1'b0, 2'b00, 16'hA5C3);
    rd(1'b0, 2'b00, v); check(v == 16'hA5C3, "R9 ctrl layout", v, 16'hA5C3);
    wr(1'b0, 2'b00, 16'h0000);
  endtask

  task automatic t_masks();
    logic ev, evn;
    for (int c = 0; c < 16; c++) begin
      wr(1'b0, 2'b00, {2'b11, 4'(c), 2'b00, 8'hFF});
      for (int p = 0; p < 10; p++) begin
        bit h = 0;
        logic [7:0] mo = a_mon, d = a_day, w = a_wday, hr = a_hour, mi = a_min, s = a_sec;
        case (p)
          1: h = 1;
          2: s = 8'h35;
          3: s = 8'h46;
          4: mi = 8'h20;
          5: mi = 8'h31;
          6: hr = 8'h15;
          7: w = 8'h04;
          8: d = 8'h26;
          9: mo = 8'h11;
          default: ;
        endcase
        set_now(h, mo, d, w, hr, mi, s);
        pulse_tick(ev, evn);
        if (expect_fire(c, h, mo, d, w, hr, mi, s))
          check(ev == 1'b1, (c > 9) ? "R4 reserved" : "R2 period fire", {15'd0, ev}, 16'd1);
        else
          check(ev == 1'b0, (c > 9) ? "R4 reserved" : "R2 period miss", {15'd0, ev}, 16'd0);
      end
    end
    wr(1'b0, 2'b00, 16'h0000);
  endtask

  task automatic t_leap();
    logic ev, evn;
    set_alarm(8'h02, 8'h29, 8'h00, 8'h08, 8'h00, 8'h00);
    wr(1'b0, 2'b00, {2'b11, 4'd9, 2'b00, 8'hFF});
    set_now(0, 8'h02, 8'h28, 8'h00, 8'h08, 8'h00, 8'h00); pulse_tick(ev, evn);
    check(ev == 1'b0, "R3 Feb 28 silent", {15'd0, ev}, 16'd0);
    set_now(0, 8'h03, 8'h01, 8'h00, 8'h08, 8'h00, 8'h00); pulse_tick(ev, evn);
    check(ev == 1'b0, "R3 Mar 01 silent", {15'd0, ev}, 16'd0);
    set_now(0, 8'h02, 8'h29, 8'h00, 8'h08, 8'h00, 8'h00); pulse_tick(ev, evn);
    check(ev == 1'b1, "R3 Feb 29 fires", {15'd0, ev}, 16'd1);
    wr(1'b0, 2'b00, 16'h0000);
  endtask

  task automatic t_pulse();
    logic ev, evn;
    wr(1'b0, 2'b00, {2'b01, 4'd0, 2'b00, 8'hFF});
    pulse_tick(ev, evn);
    check(ev == 1'b0, "R5 disarmed silent", {15'd0, ev}, 16'd0);
    wr(1'b0, 2'b00, {2'b11, 4'd0, 2'b00, 8'hFF});
    @(negedge clk); @(negedge clk);
    check(alarm_evt == 1'b0, "R5 no tick no evt", {15'd0, alarm_evt}, 16'd0);
    pulse_tick(ev, evn);
    check(ev == 1'b1, "R5 tick fires", {15'd0, ev}, 16'd1);
    check(evn == 1'b0, "R5 single cycle", {15'd0, evn}, 16'd0);
    wr(1'b0, 2'b00, 16'h0000);
  endtask

  task automatic t_oneshot();
    logic ev, evn;
    logic [15:0] v;
    wr(1'b0, 2'b00, {2'b10, 4'd0, 2'b00, 8'h02});
    pulse_tick(ev, evn); rd(1'b0, 2'b00, v);
    check(ev && v == 16'h8001, "R6 2->1 armed", v, 16'h8001);
    pulse_tick(ev, evn); rd(1'b0, 2'b00, v);
    check(ev && v == 16'h8000, "R6 1->0 armed", v, 16'h8000);
    pulse_tick(ev, evn); rd(1'b0, 2'b00, v);
    check(ev && v == 16'h0000, "R7 hold 0 and disarm", v, 16'h0000);
    pulse_tick(ev, evn);
    check(ev == 1'b0, "R7 no event after disarm", {15'd0, ev}, 16'd0);
  endtask

  task automatic t_chime();
    logic ev, evn;
    logic [15:0] v;
    wr(1'b0, 2'b00, {2'b11, 4'd0, 2'b00, 8'h00});
    pulse_tick(ev, evn); rd(1'b0, 2'b00, v);
    check(ev && v == 16'hC0FF, "R8 wrap to FF", v, 16'hC0FF);
    pulse_tick(ev, evn); rd(1'b0, 2'b00, v);
    check(ev && v == 16'hC0FE, "R8 continues FE", v, 16'hC0FE);
    wr(1'b0, 2'b00, 16'h0000);
  endtask

  task automatic t_collide();
    logic ev;
    logic [15:0] v;
    wr(1'b0, 2'b00, {2'b10, 4'd0, 2'b00, 8'h00});
    @(negedge clk);
    tick = 1'b1; reg_sel = 1'b0; reg_wdata = 16'h8005; reg_wr = 1'b1;
    @(negedge clk);
    tick = 1'b0; reg_wr = 1'b0; ev = alarm_evt;
    check(ev == 1'b1, "R13 event still pulses", {15'd0, ev}, 16'd1);
    rd(1'b0, 2'b00, v);
    check(v == 16'h8005, "R13 software value wins", v, 16'h8005);
    wr(1'b0, 2'b00, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_window();
    t_masks();
    t_leap();
    t_pulse();
    t_oneshot();
    t_chime();
    t_collide();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule